// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block carries single data words between two ports that run on unrelated clocks. It sits beside a FIFO. One mailbox register moves a word from the A port to the B port. The other moves a word from the B port to the A port. Each mailbox has an active-low occupancy flag on its writer's port. A successful write pulls the flag low. While the flag is low, any further write to that mailbox is refused. The flag returns high only after the far side has read the word.

Each mailbox flag is formed from a toggle-based handshake. The writer toggles a bit on every accepted write, and the reader toggles a bit on every accepted read. Each bit crosses into the opposite clock domain through a chain of synchronising flops. The reader acknowledges a word only after the writer's toggle has emerged from that chain.

The B port's data output selects between the A-to-B mailbox and a FIFO word supplied from outside the block. Pad three-state behaviour is represented by an output-enable per port, and a disabled output drives zero. Two resets are provided. The full reset clears the flags and both mailbox registers. The partial reset clears the flags but keeps the stored words.

Top module: `mbx_pair`

## Requirements
- R1: On a rising clk_a with a_mbx_sel=1 and a_wr_nrd=1 (A write) while a_mail1_flag_n is 1, the word on a_din is stored in mail1 and a_mail1_flag_n reads 0 after that edge.
- R2: While a_mail1_flag_n is 0, an A write to mail1 is ignored: mail1 keeps its word and the flag stays 0.
- R3: A B read of mail1 (b_mbx_sel=1, b_wr_nrd=1) made after the A write has crossed the synchroniser returns a_mail1_flag_n to 1 within five clk_a cycles of that read.
- R4: A B read of mail1 made on either of the first two clk_b edges after the A write, before the toggle has passed the two-flop synchroniser, is ignored, and a_mail1_flag_n stays 0.
- R5: On a rising clk_b with b_mbx_sel=1 and b_wr_nrd=0 (B write) while b_mail2_flag_n is 1, b_din is stored in mail2 and the flag reads 0. While the flag is 0, B writes to mail2 are ignored.
- R6: An A read of mail2 (a_mbx_sel=1, a_wr_nrd=0) presents mail2 on a_dout. Once the B write has crossed the synchroniser, that read returns b_mail2_flag_n to 1 within five clk_b cycles.
- R7: The B output is enabled when b_wr_nrd=1. While enabled, b_dout equals mail1 when b_mbx_sel=1 and b_fifo_din when b_mbx_sel=0. With b_wr_nrd=0, b_oe is 0 and b_dout is zero.
- R8: The A output is enabled when a_wr_nrd=0, and a_dout then equals mail2. With a_wr_nrd=1, a_oe is 0 and a_dout is zero.
- R9: Full reset (rst_n=0) drives both flags to 1 and clears both mailbox words to zero.
- R10: Partial reset (prst_n=0) drives both flags to 1 and keeps both mailbox words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | A port clock |
| clk_b | input | 1 | B port clock, unrelated to clk_a |
| rst_n | input | 1 | Full reset, asynchronous, active low |
| prst_n | input | 1 | Partial reset, asynchronous, active low |
| a_mbx_sel | input | 1 | A port targets a mailbox when 1 |
| a_wr_nrd | input | 1 | A port: 1 selects write, 0 selects read |
| a_din | input | DATA_W | A port write data |
| a_dout | output | DATA_W | A port read data (mail2), zero when disabled |
| a_oe | output | 1 | A port output enable |
| a_mail1_flag_n | output | 1 | Low while mail1 holds an unread word |
| b_mbx_sel | input | 1 | B port targets a mailbox when 1 |
| b_wr_nrd | input | 1 | B port: 0 selects write, 1 selects read |
| b_din | input | DATA_W | B port write data |
| b_fifo_din | input | DATA_W | FIFO word offered to the B output |
| b_dout | output | DATA_W | B port read data, zero when disabled |
| b_oe | output | 1 | B port output enable |
| b_mail2_flag_n | output | 1 | Low while mail2 holds an unread word |

## Verification
The bench repeats every write before the far side reads it. A design that accepted the second write would return the wrong word. It also reads mail1 on the B side before the write has crossed the synchroniser. A design that acknowledged on unsynchronised state would release the flag while the word was still unread. A partial reset is issued while a word is pending, and the bench checks that the flags are released and the word is kept. A design that wired partial reset into the data registers would read back zero. A full reset that left the data in place would show the old word on b_dout.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DATA_W_DEF = 36;
  localparam int SYNC_STAGES_DEF = 2;

  typedef struct packed {
    logic mbx_wr;
    logic mbx_rd;
    logic oe;
  } side_req_t;

  function automatic side_req_t decode_side(input logic sel, input logic is_write);
    side_req_t r;
    r.mbx_wr = sel & is_write;
    r.mbx_rd = sel & ~is_write;
    r.oe     = ~is_write;
    return r;
  endfunction
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int DATA_W = 36,
  parameter int STAGES = 2
) (
  input  logic              wclk,
  input  logic              w_flag_rst_n,
  input  logic              w_data_rst_n,
  input  logic              w_req,
  input  logic [DATA_W-1:0] w_data,
  output logic              w_flag_n,
  input  logic              rclk,
  input  logic              r_rst_n,
  input  logic              r_req,
  output logic [DATA_W-1:0] mail_q
);
  logic              w_tog_q, w_tog_d;
  logic              ack_seen;
  logic              w_accept;
  logic [DATA_W-1:0] mail_d;
  logic              tog_seen;
  logic              r_ack_q, r_ack_d;
  logic              r_pending;
  logic              r_accept;

  // writer domain
  mbx_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk(wclk), .rst_n(w_flag_rst_n), .d(r_ack_q), .q(ack_seen)
  );

  always_comb begin
    w_flag_n = (w_tog_q == ack_seen);
    w_accept = w_req & w_flag_n;
    w_tog_d  = w_tog_q ^ w_accept;
    mail_d   = w_accept ? w_data : mail_q;
  end

  always_ff @(posedge wclk or negedge w_flag_rst_n) begin
    if (!w_flag_rst_n) w_tog_q <= 1'b0;
    else               w_tog_q <= w_tog_d;
  end

  always_ff @(posedge wclk or negedge w_data_rst_n) begin
    if (!w_data_rst_n) mail_q <= '0;
    else if (w_accept) mail_q <= mail_d;
  end

  // reader domain
  mbx_sync #(.STAGES(STAGES)) u_tog_sync (
    .clk(rclk), .rst_n(r_rst_n), .d(w_tog_q), .q(tog_seen)
  );

  always_comb begin
    r_pending = (tog_seen != r_ack_q);
    r_accept  = r_req & r_pending;
    r_ack_d   = r_ack_q ^ r_accept;
  end

  always_ff @(posedge rclk or negedge r_rst_n) begin
    if (!r_rst_n) r_ack_q <= 1'b0;
    else          r_ack_q <= r_ack_d;
  end
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
  import mbx_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst_n,
  input  logic              prst_n,
  input  logic              a_mbx_sel,
  input  logic              a_wr_nrd,
  input  logic [DATA_W-1:0] a_din,
  output logic [DATA_W-1:0] a_dout,
  output logic              a_oe,
  output logic              a_mail1_flag_n,
  input  logic              b_mbx_sel,
  input  logic              b_wr_nrd,
  input  logic [DATA_W-1:0] b_din,
  input  logic [DATA_W-1:0] b_fifo_din,
  output logic [DATA_W-1:0] b_dout,
  output logic              b_oe,
  output logic              b_mail2_flag_n
);
  localparam int NUM_DOM = 2;

  logic              any_rst_n;
  logic [NUM_DOM-1:0] dom_clk;
  logic [NUM_DOM-1:0] dom_full_n;
  logic [NUM_DOM-1:0] dom_any_n;
  logic              a_rst_full_n, a_rst_any_n, b_rst_full_n, b_rst_any_n;
  side_req_t         a_req, b_req;
  logic [DATA_W-1:0] mail1_q, mail2_q;

  assign any_rst_n = rst_n & prst_n;
  assign dom_clk   = {clk_b, clk_a};

  // reset release synchronisers, one pair per clock domain
  for (genvar g = 0; g < NUM_DOM; g++) begin : g_rst
    mbx_sync #(.STAGES(SYNC_STAGES)) u_full (
      .clk(dom_clk[g]), .rst_n(rst_n), .d(1'b1), .q(dom_full_n[g])
    );
    mbx_sync #(.STAGES(SYNC_STAGES)) u_any (
      .clk(dom_clk[g]), .rst_n(any_rst_n), .d(1'b1), .q(dom_any_n[g])
    );
  end

  assign a_rst_full_n = dom_full_n[0];
  assign a_rst_any_n  = dom_any_n[0];
  assign b_rst_full_n = dom_full_n[1];
  assign b_rst_any_n  = dom_any_n[1];

  always_comb begin
    a_req = decode_side(a_mbx_sel, a_wr_nrd);
    b_req = decode_side(b_mbx_sel, ~b_wr_nrd);
  end

  // mail1: A writes, B reads
  mbx_channel #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_mail1 (
    .wclk(clk_a), .w_flag_rst_n(a_rst_any_n), .w_data_rst_n(a_rst_full_n),
    .w_req(a_req.mbx_wr), .w_data(a_din), .w_flag_n(a_mail1_flag_n),
    .rclk(clk_b), .r_rst_n(b_rst_any_n), .r_req(b_req.mbx_rd),
    .mail_q(mail1_q)
  );

  // mail2: B writes, A reads
  mbx_channel #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_mail2 (
    .wclk(clk_b), .w_flag_rst_n(b_rst_any_n), .w_data_rst_n(b_rst_full_n),
    .w_req(b_req.mbx_wr), .w_data(b_din), .w_flag_n(b_mail2_flag_n),
    .rclk(clk_a), .r_rst_n(a_rst_any_n), .r_req(a_req.mbx_rd),
    .mail_q(mail2_q)
  );

  always_comb begin
    a_oe   = a_req.oe;
    b_oe   = b_req.oe;
    a_dout = a_oe ? mail2_q : '0;
    if (!b_oe)          b_dout = '0;
    else if (b_mbx_sel) b_dout = mail1_q;
    else                b_dout = b_fifo_din;
  end
endmodule

// File: rtl/mbx_pair_chk.sv
module mbx_pair_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk_a,
  input logic              clk_b,
  input logic              rst_n,
  input logic              a_rst_any_n,
  input logic              b_rst_any_n,
  input logic              a_mbx_sel,
  input logic              a_wr_nrd,
  input logic [DATA_W-1:0] a_din,
  input logic [DATA_W-1:0] a_dout,
  input logic              a_mail1_flag_n,
  input logic              b_mbx_sel,
  input logic              b_wr_nrd,
  input logic [DATA_W-1:0] b_din,
  input logic [DATA_W-1:0] b_fifo_din,
  input logic [DATA_W-1:0] b_dout,
  input logic              b_mail2_flag_n,
  input logic [DATA_W-1:0] mail1_q,
  input logic [DATA_W-1:0] mail2_q
);
  AST_MAIL1_TAKE: assert property (@(posedge clk_a) disable iff (!a_rst_any_n)
    (a_mbx_sel && a_wr_nrd && a_mail1_flag_n) |=> (!a_mail1_flag_n && mail1_q == $past(a_din))); // R1
  AST_MAIL1_HOLD: assert property (@(posedge clk_a) disable iff (!a_rst_any_n)
    (!a_mail1_flag_n) |=> $stable(mail1_q)); // R2
  AST_MAIL2_TAKE: assert property (@(posedge clk_b) disable iff (!b_rst_any_n)
    (b_mbx_sel && !b_wr_nrd && b_mail2_flag_n) |=> (!b_mail2_flag_n && mail2_q == $past(b_din))); // R5
  AST_MAIL2_HOLD: assert property (@(posedge clk_b) disable iff (!b_rst_any_n)
    (!b_mail2_flag_n) |=> $stable(mail2_q)); // R5
  AST_B_FIFO_PATH: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_wr_nrd && !b_mbx_sel) |-> (b_dout == b_fifo_din)); // R7
  AST_B_QUIET: assert property (@(posedge clk_b) disable iff (!rst_n)
    (!b_wr_nrd) |-> (b_dout == '0)); // R7
  AST_A_QUIET: assert property (@(posedge clk_a) disable iff (!rst_n)
    a_wr_nrd |-> (a_dout == '0)); // R8
endmodule

bind mbx_pair mbx_pair_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_mbx_pair.sv
`timescale 1ns/1ps
module sim_mbx_pair;
  localparam int W = 36;
  localparam int NV = 4;
  // stimulus word, duplicate (must be dropped), expected read = stimulus
  localparam logic [W-1:0] VEC_M1 [NV] = '{36'h0_1234_5678, 36'hF_FFFF_FFFF, 36'h0_0000_0001, 36'hA_5A5A_5A5A};
  localparam logic [W-1:0] VEC_M2 [NV] = '{36'h8_7654_3210, 36'h0_0000_0000, 36'h5_A5A5_A5A5, 36'h3_C3C3_C3C3};

  logic clk_a = 0, clk_b = 0;
  logic rst_n, prst_n;
  logic a_mbx_sel, a_wr_nrd, b_mbx_sel, b_wr_nrd;
  logic [W-1:0] a_din, b_din, b_fifo_din, a_dout, b_dout;
  logic a_oe, b_oe, a_mail1_flag_n, b_mail2_flag_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk_a = ~clk_a;
  initial begin #3; forever #7 clk_b = ~clk_b; end

  mbx_pair u0 (.*);

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic a_drive(input logic sel, input logic wr, input logic [W-1:0] d);
    @(negedge clk_a); a_mbx_sel = sel; a_wr_nrd = wr; a_din = d;
  endtask
  task automatic b_drive(input logic sel, input logic wr, input logic [W-1:0] d);
    @(negedge clk_b); b_mbx_sel = sel; b_wr_nrd = wr; b_din = d;
  endtask
  task automatic a_wait(input int n); repeat (n) @(negedge clk_a); endtask
  task automatic b_wait(input int n); repeat (n) @(negedge clk_b); endtask

  initial begin
    rst_n = 0; prst_n = 1;
    a_mbx_sel = 0; a_wr_nrd = 1; a_din = '0;
    b_mbx_sel = 0; b_wr_nrd = 0; b_din = '0; b_fifo_din = 36'h7_0F0F_0F0F;
    a_wait(5); rst_n = 1; a_wait(5);
    chk("R9 flag1 after reset", a_mail1_flag_n, 1);
    chk("R9 flag2 after reset", b_mail2_flag_n, 1);
    chk("R8 a_dout disabled", a_dout, '0);
    chk("R7 b_dout disabled", b_dout, '0);

    for (int i = 0; i < NV; i++) begin
      // mail1: A to B
      a_drive(1, 1, VEC_M1[i]); a_drive(0, 1, '0);
      chk("R1 flag1 low after write", a_mail1_flag_n, 0);
      a_drive(1, 1, ~VEC_M1[i]); a_drive(0, 1, '0);
      chk("R2 flag1 stays low", a_mail1_flag_n, 0);
      b_wait(4);
      b_drive(1, 1, '0); #1;
      chk("R2 mail1 read keeps first word", b_dout, VEC_M1[i]);
      b_drive(0, 0, '0);
      a_wait(5);
      chk("R3 flag1 released", a_mail1_flag_n, 1);
      // mail2: B to A
      b_drive(1, 0, VEC_M2[i]); b_drive(0, 0, '0);
      chk("R5 flag2 low after write", b_mail2_flag_n, 0);
      b_drive(1, 0, ~VEC_M2[i]); b_drive(0, 0, '0);
      chk("R5 flag2 stays low", b_mail2_flag_n, 0);
      a_wait(4);
      a_drive(1, 0, '0); #1;
      chk("R6 mail2 read data", a_dout, VEC_M2[i]);
      chk("R8 a_oe on read", a_oe, 1);
      a_drive(0, 1, '0);
      b_wait(5);
      chk("R6 flag2 released", b_mail2_flag_n, 1);
    end

    // R7 FIFO path and disable
    b_drive(0, 1, '0); #1;
    chk("R7 fifo data on b_dout", b_dout, b_fifo_din);
    chk("R7 b_oe on read", b_oe, 1);
    b_drive(0, 0, '0); #1;
    chk("R7 b_oe off on write", b_oe, 0);

    // R4 early read ignored
    a_drive(1, 1, 36'h1_1111_2222); a_drive(0, 1, '0);
    b_drive(1, 1, '0); b_drive(0, 0, '0);
    a_wait(8);
    chk("R4 early read ignored", a_mail1_flag_n, 0);
    b_drive(1, 1, '0); b_drive(0, 0, '0);
    a_wait(5);
    chk("R4 later read releases", a_mail1_flag_n, 1);

    // R10 partial reset keeps data
    a_drive(1, 1, 36'h0_0000_0ABC); a_drive(0, 1, '0);
    b_drive(1, 0, 36'h0_0000_0DEF); b_drive(0, 0, '0);
    chk("R10 flag2 low before partial reset", b_mail2_flag_n, 0);
    prst_n = 0; a_wait(3); prst_n = 1; a_wait(4);
    chk("R10 flag1 high", a_mail1_flag_n, 1);
    chk("R10 flag2 high", b_mail2_flag_n, 1);
    b_drive(1, 1, '0); #1;
    chk("R10 mail1 kept", b_dout, 36'h0_0000_0ABC);
    b_drive(0, 0, '0);
    a_drive(1, 0, '0); #1;
    chk("R10 mail2 kept", a_dout, 36'h0_0000_0DEF);
    a_drive(0, 1, '0);

    // R9 full reset clears data
    a_drive(1, 1, 36'h0_0000_0777); a_drive(0, 1, '0);
    rst_n = 0; a_wait(3); rst_n = 1; a_wait(4);
    chk("R9 flag1 high after full reset", a_mail1_flag_n, 1);
    b_drive(1, 1, '0); #1;
    chk("R9 mail1 cleared", b_dout, '0);
    b_drive(0, 0, '0);
    a_drive(1, 0, '0); #1;
    chk("R9 mail2 cleared", a_dout, '0);
    a_drive(0, 1, '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_a);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule